// File: doc/BRIEF.md
# Two-Wire Bus Low-Time Watchdog

This block listens to the clock and data lines of a two-wire management bus and polices three separate limits on how long the clock may be held low. The first limit applies to any single low interval of the clock, whether or not a message is in progress. The second is a message-wide budget that covers the extra low time the local device adds while it acts as target. The third is a per-byte budget that covers the extra low time the local device adds while it acts as controller. Both lines pass through a synchronizer. START and STOP conditions are then recovered from the synchronized lines, and clock rising edges are counted so that acknowledge positions can be found.

Extension time is the part of a clock-low interval that runs past a nominal low time. The role input chooses which budget receives that time. When any limit is crossed, the block pulses a cause vector and a release request for one cycle. The surrounding interface uses the release request to let go of both lines and reinitialise. The block also ends its view of the current message and keeps a sticky record of the cause, which stays set until it is cleared. All limits are given in milliseconds or microseconds and are turned into cycle counts from a system-clock frequency parameter.

Top module: `twb_timeout_mon`

## Requirements
- R1: A START (data falling while the clock is high on two consecutive synchronized samples) sets `msg_active_o`. A STOP (data rising while the clock is high on two consecutive synchronized samples) clears it.
- R2: When a single synchronized clock-low run lasts more than TLOW_MS milliseconds of cycles, `hit_o[0]` pulses for exactly one cycle. It pulses only once per run and also fires outside a message.
- R3: Within each clock-low run, only the cycles after the first NOM_LOW_US microseconds of cycles count as extension.
- R4: With `ctrl_role_i` = 0 and a message active, extension accumulates from the first START. `hit_o[1]` pulses on the cycle after the total exceeds TGT_MS milliseconds of cycles. A repeated START does not reset this total.
- R5: A STOP resets the target total, so each new message starts with the full budget.
- R6: With `ctrl_role_i` = 1 and a message active, `hit_o[2]` pulses on the cycle after the extension within one byte segment exceeds CTL_MS milliseconds of cycles.
- R7: The ninth clock rising edge after a START, a repeated START or the previous acknowledge marks an acknowledge. The acknowledge closes the controller segment and starts a new one with an empty total. START and STOP also start a new segment.
- R8: `rel_req_o` pulses in exactly the cycles where `hit_o` is non-zero. `hit_o` has at most one bit set. Bit 0 is the low-run limit, bit 1 the target budget and bit 2 the controller budget.
- R9: Any hit ends the message: `msg_active_o` is low in the hit cycle, and both budget totals restart from zero.
- R10: Each `hit_o` bit sets the same bit of `sticky_o`. A set bit holds until `sticky_clr_i` is high at a clock edge. A hit on the same edge as a clear still sets its bit.
- R11: Synchronous reset clears all outputs. Reset returns the line view to idle high.
- R12: Extension is charged only to the budget of the current role. The other role's total does not grow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| scl_i | input | 1 | Sampled bus clock line |
| sda_i | input | 1 | Sampled bus data line |
| ctrl_role_i | input | 1 | 1 when the local device is controller, 0 when target |
| sticky_clr_i | input | 1 | Clears the sticky cause bits |
| hit_o | output | 3 | One-cycle cause pulse: [0] low run, [1] target budget, [2] controller budget |
| rel_req_o | output | 1 | One-cycle request to release both lines and reset the interface |
| sticky_o | output | 3 | Sticky copy of the cause bits |
| msg_active_o | output | 1 | A message is open between START and STOP |

## Verification
The assertions assume that a pin change reaches the counters two clocks later, through the synchronizer. They also assume that `sticky_clr_i` and `ctrl_role_i` are plain synchronous inputs that need no filtering. The stimulus changes only on the falling clock edge. It never moves data in the same cycle as a clock rising edge, so START, STOP and rising edges are never ambiguous. The role is changed only while the bus is idle, which keeps every budget tied to one role for the whole message.

// File: rtl/twb_mon_pkg.sv
package twb_mon_pkg;

   localparam int N_CAUSE      = 3;
   localparam int HIT_LOW      = 0;
   localparam int HIT_TGT      = 1;
   localparam int HIT_CTL      = 2;
   localparam int BITS_PER_SEG = 9;

   function automatic int unsigned ms_cycles(input int unsigned clk_hz, input int unsigned ms);
      return (clk_hz / 1000) * ms;
   endfunction

   function automatic int unsigned us_cycles(input int unsigned clk_hz, input int unsigned us);
      return ((clk_hz / 1000) * us) / 1000;
   endfunction

endpackage

// File: rtl/twb_line_sync.sv
module twb_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_o,
   output logic rise_o,
   output logic start_o,
   output logic stop_o
);

   localparam int N_LINE = 2;

   logic [N_LINE-1:0] pin_w;
   logic [N_LINE-1:0] cur_w;
   logic [N_LINE-1:0] prv_q;
   logic              clk_high;

   assign pin_w = {sda_i, scl_i};

   for (genvar g = 0; g < N_LINE; g++) begin : g_line
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk_i) begin
         if (rst_i) chain_q <= '1;
         else       chain_q <= {chain_q[STAGES-2:0], pin_w[g]};
      end
      assign cur_w[g] = chain_q[STAGES-1];
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) prv_q <= '1;
      else       prv_q <= cur_w;
   end

   assign clk_high = cur_w[0] & prv_q[0];
   assign scl_o    = cur_w[0];
   assign rise_o   = cur_w[0] & ~prv_q[0];
   assign start_o  = clk_high & prv_q[1] & ~cur_w[1];
   assign stop_o   = clk_high & ~prv_q[1] & cur_w[1];

endmodule

// File: rtl/twb_low_timer.sv
module twb_low_timer #(
   parameter int unsigned LIMIT = 100,
   parameter int unsigned NOM   = 10
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic scl_i,
   output logic low_hit_o,
   output logic ext_o
);

   localparam int W = $clog2(LIMIT + 2);
   localparam logic [W-1:0] LIM_V = W'(LIMIT);
   localparam logic [W-1:0] SAT_V = W'(LIMIT + 1);
   localparam logic [W-1:0] NOM_V = W'(NOM);

   logic [W-1:0] run_q;

   always_ff @(posedge clk_i) begin
      if (rst_i || scl_i)     run_q <= '0;
      else if (run_q != SAT_V) run_q <= run_q + 1'b1;
   end

   assign low_hit_o = ~scl_i & (run_q == LIM_V);
   assign ext_o     = ~scl_i & (run_q >= NOM_V);

endmodule

// File: rtl/twb_budget.sv
module twb_budget #(
   parameter int unsigned LIMIT = 100
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic clr_i,
   input  logic inc_i,
   output logic hit_o
);

   localparam int W = $clog2(LIMIT + 1);
   localparam logic [W-1:0] LIM_V = W'(LIMIT);

   logic [W-1:0] acc_q;

   always_ff @(posedge clk_i) begin
      if (rst_i || clr_i)             acc_q <= '0;
      else if (inc_i && acc_q != LIM_V) acc_q <= acc_q + 1'b1;
   end

   assign hit_o = inc_i & (acc_q == LIM_V);

endmodule

// File: rtl/twb_seg_track.sv
module twb_seg_track #(
   parameter int BITS = 9
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic active_i,
   input  logic rise_i,
   input  logic restart_i,
   output logic ack_o
);

   localparam int W = $clog2(BITS);
   localparam logic [W-1:0] LAST_V = W'(BITS - 1);

   logic [W-1:0] cnt_q;

   assign ack_o = active_i & rise_i & (cnt_q == LAST_V);

   always_ff @(posedge clk_i) begin
      if (rst_i || restart_i)      cnt_q <= '0;
      else if (active_i && rise_i) cnt_q <= ack_o ? '0 : cnt_q + 1'b1;
   end

endmodule

// File: rtl/twb_timeout_mon.sv
module twb_timeout_mon
   import twb_mon_pkg::*;
#(
   parameter int unsigned CLK_HZ     = 100_000_000,
   parameter int unsigned TLOW_MS    = 30,
   parameter int unsigned TGT_MS     = 25,
   parameter int unsigned CTL_MS     = 10,
   parameter int unsigned NOM_LOW_US = 5,
   parameter int          SYNC_STAGES = 2
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic               scl_i,
   input  logic               sda_i,
   input  logic               ctrl_role_i,
   input  logic               sticky_clr_i,
   output logic [N_CAUSE-1:0] hit_o,
   output logic               rel_req_o,
   output logic [N_CAUSE-1:0] sticky_o,
   output logic               msg_active_o
);

   localparam int unsigned TLOW_CYC = ms_cycles(CLK_HZ, TLOW_MS);
   localparam int unsigned TGT_CYC  = ms_cycles(CLK_HZ, TGT_MS);
   localparam int unsigned CTL_CYC  = ms_cycles(CLK_HZ, CTL_MS);
   localparam int unsigned NOM_CYC  = us_cycles(CLK_HZ, NOM_LOW_US);

   if (CLK_HZ < 1000) begin : g_bad_clk
      $error("CLK_HZ must give at least one cycle per millisecond");
   end
   if (TLOW_MS < 25 || TLOW_MS > 35) begin : g_bad_tlow
      $error("TLOW_MS must lie in the 25..35 window");
   end
   if (TGT_MS == 0 || CTL_MS == 0) begin : g_bad_budget
      $error("budgets must be non-zero");
   end
   if (NOM_CYC >= TLOW_CYC) begin : g_bad_nom
      $error("nominal low time must be shorter than the low limit");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic scl_s, rise, start_ev, stop_ev;
   logic low_hit, ext_tick, ack_ev;
   logic tgt_hit, ctl_hit, abort;
   logic tgt_clr, ctl_clr, tgt_inc, ctl_inc;
   logic msg_q;
   logic [N_CAUSE-1:0] hit_d;
   logic [N_CAUSE-1:0] hit_q, sticky_q;
   logic               rel_q;

   twb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .scl_i   (scl_i),
      .sda_i   (sda_i),
      .scl_o   (scl_s),
      .rise_o  (rise),
      .start_o (start_ev),
      .stop_o  (stop_ev)
   );

   twb_low_timer #(.LIMIT(TLOW_CYC), .NOM(NOM_CYC)) u_low (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .scl_i     (scl_s),
      .low_hit_o (low_hit),
      .ext_o     (ext_tick)
   );

   twb_seg_track #(.BITS(BITS_PER_SEG)) u_seg (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .active_i  (msg_q),
      .rise_i    (rise),
      .restart_i (start_ev | stop_ev | abort),
      .ack_o     (ack_ev)
   );

   assign tgt_inc = ext_tick & msg_q & ~ctrl_role_i;
   assign ctl_inc = ext_tick & msg_q & ctrl_role_i;
   assign tgt_clr = stop_ev | abort | (start_ev & ~msg_q);
   assign ctl_clr = start_ev | stop_ev | ack_ev | abort;

   twb_budget #(.LIMIT(TGT_CYC)) u_tgt (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .clr_i (tgt_clr),
      .inc_i (tgt_inc),
      .hit_o (tgt_hit)
   );

   twb_budget #(.LIMIT(CTL_CYC)) u_ctl (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .clr_i (ctl_clr),
      .inc_i (ctl_inc),
      .hit_o (ctl_hit)
   );

   always_comb begin
      hit_d          = '0;
      hit_d[HIT_LOW] = low_hit;
      hit_d[HIT_TGT] = tgt_hit;
      hit_d[HIT_CTL] = ctl_hit;
   end

   assign abort = |hit_d;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         msg_q    <= 1'b0;
         hit_q    <= '0;
         rel_q    <= 1'b0;
         sticky_q <= '0;
      end else begin
         if (abort || stop_ev) msg_q <= 1'b0;
         else if (start_ev)    msg_q <= 1'b1;
         hit_q    <= hit_d;
         rel_q    <= abort;
         sticky_q <= (sticky_clr_i ? '0 : sticky_q) | hit_d;
      end
   end

   assign hit_o        = hit_q;
   assign rel_req_o    = rel_q;
   assign sticky_o     = sticky_q;
   assign msg_active_o = msg_q;

endmodule

// File: rtl/twb_timeout_mon_chk.sv
module twb_timeout_mon_chk (
   input logic       clk_i,
   input logic       rst_i,
   input logic       scl_i,
   input logic       sticky_clr_i,
   input logic [2:0] hit_o,
   input logic       rel_req_o,
   input logic [2:0] sticky_o,
   input logic       msg_active_o
);

   p_cause_onehot_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      $onehot0(hit_o));

   p_rel_tracks_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      rel_req_o == (hit_o != 3'b000));

   p_low_pulse_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      hit_o[0] |=> !hit_o[0]);

   p_low_needs_low_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      hit_o[0] |-> !$past(scl_i, 2));

   p_hit_sets_r10: assert property (@(posedge clk_i) disable iff (rst_i)
      (hit_o != 3'b000) |-> ((sticky_o & hit_o) == hit_o));

   p_sticky_keep_r10: assert property (@(posedge clk_i) disable iff (rst_i)
      !sticky_clr_i |=> ((sticky_o & $past(sticky_o)) == $past(sticky_o)));

   p_hit_ends_msg_r9: assert property (@(posedge clk_i) disable iff (rst_i)
      (hit_o != 3'b000) |-> !msg_active_o);

endmodule

bind twb_timeout_mon twb_timeout_mon_chk u_chk (
   .clk_i        (clk_i),
   .rst_i        (rst_i),
   .scl_i        (scl_i),
   .sticky_clr_i (sticky_clr_i),
   .hit_o        (hit_o),
   .rel_req_o    (rel_req_o),
   .sticky_o     (sticky_o),
   .msg_active_o (msg_active_o)
);

// File: tb/sim_twb_timeout_mon.sv
`timescale 1ns/1ps
module sim_twb_timeout_mon;

   // Scale: CLK_HZ of 10 kHz gives 10 cycles per millisecond, so the
   // limits become 300 (low run), 250 (target), 100 (controller), 5 (nominal).
   localparam int TLOW = 300;
   localparam int TGT  = 250;
   localparam int CTL  = 100;
   localparam int NOM  = 5;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic scl = 1'b1;
   logic sda = 1'b1;
   logic role = 1'b0;
   logic clr = 1'b0;
   logic [2:0] hit, sticky;
   logic rel, msg;

   always #2.5 clk = ~clk;

   twb_timeout_mon #(
      .CLK_HZ(10_000), .TLOW_MS(30), .TGT_MS(25), .CTL_MS(10), .NOM_LOW_US(500)
   ) u0 (
      .clk_i(clk), .rst_i(rst), .scl_i(scl), .sda_i(sda),
      .ctrl_role_i(role), .sticky_clr_i(clr),
      .hit_o(hit), .rel_req_o(rel), .sticky_o(sticky), .msg_active_o(msg)
   );

   int n_chk = 0;
   int n_fail = 0;
   int n_hit [3];
   int n_sticky0 = 0;
   int cyc = 0;
   bit started = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   bit q_scl[$];
   bit q_sda[$];
   bit m_p_scl, m_p_sda, m_msg, m_rel;
   int m_low, m_tacc, m_cacc, m_bits;
   bit [2:0] m_hit, m_sticky;

   always @(posedge clk) begin
      bit s_scl, s_sda, rise, st, sp, ext, ack, tinc, cinc, any;
      bit [2:0] h;
      started = 1;
      cyc++;
      if (rst) begin
         q_scl = '{1'b1, 1'b1};
         q_sda = '{1'b1, 1'b1};
         m_p_scl = 1; m_p_sda = 1; m_msg = 0; m_rel = 0;
         m_low = 0; m_tacc = 0; m_cacc = 0; m_bits = 0;
         m_hit = 0; m_sticky = 0;
      end else begin
         s_scl = q_scl[0];
         s_sda = q_sda[0];
         rise = s_scl && !m_p_scl;
         st   = s_scl && m_p_scl && m_p_sda && !s_sda;
         sp   = s_scl && m_p_scl && !m_p_sda && s_sda;
         ext  = !s_scl && (m_low >= NOM);
         h[0] = !s_scl && (m_low == TLOW);
         ack  = rise && m_msg && (m_bits == 8);
         tinc = ext && m_msg && !role;
         cinc = ext && m_msg && role;
         h[1] = tinc && (m_tacc == TGT);
         h[2] = cinc && (m_cacc == CTL);
         any  = |h;
         m_low = s_scl ? 0 : ((m_low < TLOW + 1) ? m_low + 1 : m_low);
         if (sp || any || (st && !m_msg)) m_tacc = 0;
         else if (tinc && m_tacc < TGT) m_tacc++;
         if (st || sp || ack || any) m_cacc = 0;
         else if (cinc && m_cacc < CTL) m_cacc++;
         if (st || sp || any) m_bits = 0;
         else if (rise && m_msg) m_bits = (m_bits == 8) ? 0 : m_bits + 1;
         if (any || sp) m_msg = 0;
         else if (st) m_msg = 1;
         m_hit = h;
         m_rel = any;
         m_sticky = (clr ? 3'b000 : m_sticky) | h;
         m_p_scl = s_scl;
         m_p_sda = s_sda;
         void'(q_scl.pop_front());
         void'(q_sda.pop_front());
         q_scl.push_back(scl);
         q_sda.push_back(sda);
      end
   end

   // per-clock comparison, away from the active edge
   always @(negedge clk) begin
      if (started) begin
         chk(hit[0] == m_hit[0], "R2 hit[0]", hit[0], m_hit[0]);
         chk(hit[1] == m_hit[1], "R4 hit[1]", hit[1], m_hit[1]);
         chk(hit[2] == m_hit[2], "R6 hit[2]", hit[2], m_hit[2]);
         chk(rel == m_rel, "R8 rel_req", rel, m_rel);
         chk(sticky == m_sticky, "R10 sticky", sticky, m_sticky);
         chk(msg == m_msg, "R1 msg_active", msg, m_msg);
         for (int k = 0; k < 3; k++) if (hit[k]) n_hit[k]++;
         if (sticky[0]) n_sticky0++;
      end
   end

   // watchdog
   always @(posedge clk) begin
      if (cyc > 150000) begin
         chk(1'b0, "watchdog", cyc, 150000);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   // ---------------- bus stimulus ----------------
   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clear_counts();
      for (int k = 0; k < 3; k++) n_hit[k] = 0;
      n_sticky0 = 0;
   endtask

   task automatic bus_start();
      scl = 1; sda = 1; wait_n(4);
      sda = 0; wait_n(4);
   endtask

   task automatic bus_rstart();
      scl = 0; wait_n(2);
      sda = 1; wait_n(2);
      scl = 1; wait_n(4);
      sda = 0; wait_n(4);
   endtask

   task automatic bus_stop();
      scl = 0; sda = 0; wait_n(3);
      scl = 1; wait_n(4);
      sda = 1; wait_n(6);
   endtask

   task automatic bus_bit(input int low, input bit d);
      scl = 0; sda = d; wait_n(low);
      scl = 1; wait_n(4);
   endtask

   task automatic bus_bits(input int n, input int low);
      for (int i = 0; i < n; i++) bus_bit(low, i[0]);
   endtask

   initial begin
      wait_n(3);
      // R11: reset state
      chk(hit == 0 && rel == 0, "R11 hit/rel in reset", {hit, rel}, 0);
      chk(sticky == 0 && msg == 0, "R11 sticky/msg in reset", {sticky, msg}, 0);
      rst = 0;
      wait_n(5);
      chk(hit == 0 && sticky == 0 && msg == 0, "R11 after reset", {hit, sticky, msg}, 0);

      // R1: plain message, no extension
      bus_start();
      chk(msg == 1, "R1 START opens message", msg, 1);
      bus_bits(9, NOM);
      bus_stop();
      chk(msg == 0, "R1 STOP closes message", msg, 0);

      // R2/R10: single long low run with clear held: set wins for one cycle
      clear_counts();
      clr = 1;
      scl = 0; wait_n(TLOW + 20);
      scl = 1; wait_n(8);
      clr = 0;
      chk(n_hit[0] == 1, "R2 one low-run hit", n_hit[0], 1);
      chk(n_sticky0 == 1, "R10 set beats clear", n_sticky0, 1);

      // R2: run exactly at the limit does not fire
      clear_counts();
      scl = 0; wait_n(TLOW);
      scl = 1; wait_n(8);
      chk(n_hit[0] == 0, "R2 run at limit quiet", n_hit[0], 0);

      // R10: sticky holds until cleared
      scl = 0; wait_n(TLOW + 5);
      scl = 1; wait_n(40);
      chk(sticky[0] == 1, "R10 sticky held", sticky[0], 1);
      clr = 1; wait_n(1); clr = 0; wait_n(2);
      chk(sticky == 0, "R10 sticky cleared", sticky, 0);

      // R4/R12/R9: target, repeated START keeps total (180 + 80 > 250)
      role = 0;
      clear_counts();
      bus_start();
      bus_bits(9, NOM + 20);
      bus_rstart();
      bus_bits(4, NOM + 20);
      chk(n_hit[1] == 1, "R4 target budget over rep START", n_hit[1], 1);
      chk(n_hit[2] == 0, "R12 controller total idle as target", n_hit[2], 0);
      chk(msg == 0, "R9 hit ends message", msg, 0);
      bus_stop();

      // R5: STOP refills the target budget (180 + 180 without hit)
      clear_counts();
      bus_start();
      bus_bits(9, NOM + 20);
      bus_stop();
      bus_start();
      bus_bits(9, NOM + 20);
      bus_stop();
      chk(n_hit[1] == 0, "R5 STOP resets target total", n_hit[1], 0);

      // R7/R12: controller, 99 per byte over three bytes, ACK refills
      role = 1;
      clear_counts();
      bus_start();
      bus_bits(27, NOM + 11);
      bus_stop();
      chk(n_hit[2] == 0, "R7 ACK starts new segment", n_hit[2], 0);
      chk(n_hit[1] == 0, "R12 target total idle as controller", n_hit[1], 0);

      // R3/R6: 12 extra per bit: 96 after eight bits, over on the ninth
      clear_counts();
      bus_start();
      bus_bits(8, NOM + 12);
      chk(n_hit[2] == 0, "R3 only excess cycles counted", n_hit[2], 0);
      bus_bit(NOM + 12, 0);
      chk(n_hit[2] == 1, "R6 controller byte budget", n_hit[2], 1);
      chk(sticky[2] == 1, "R10 controller cause sticky", sticky[2], 1);
      bus_stop();
      role = 0;
      wait_n(10);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule